// File: doc/BRIEF.md
# Dual-Mode Booth Multiply-Accumulate Lane

This block is a single multiply-accumulate lane whose partial products come from radix-4 Booth recoding of the second operand. A per-operation mode bit picks how that operand is read. In integer mode it is a full signed 8-bit multiplier and is recoded into four Booth digits. In ternary mode its two low bits carry a weight of -1, 0 or +1. That weight drives the least significant Booth digit directly, and the three upper digits are held at zero. Both modes feed the same partial-product generators and the same adder tree, so supporting the ternary case adds no second multiplier array.

A negative partial product is formed by inverting the shifted multiplicand and injecting a +1 carry into the adder tree. The lane has two register stages. The first stage recodes the operand and generates the partial products. The second stage reduces them and updates the accumulator. A result appears two clock edges after its operands are accepted. Because the mode travels with each operation, consecutive operations may alternate modes with no bubble and no flush. A first-of-group flag makes the accumulator load a product instead of adding it.

Top module: `booth_mac_lane`

## Requirements
- R1: In integer mode (`in_mode`=0) the product is the exact signed value of `in_act` × `in_wgt`, both read as two's complement. This includes -128 × -128 = +16384.
- R2: In ternary mode (`in_mode`=1), `in_wgt[1:0]` encodes the weight: 2'b01 is +1, 2'b11 is -1, and both 2'b00 and 2'b10 are 0. The product is `in_act` times that weight.
- R3: In ternary mode, bits `in_wgt[7:2]` have no effect on the result.
- R4: Each accepted operation (`in_valid`=1 at a rising edge) makes `out_valid` high exactly two rising edges later, for one cycle. `out_valid` is never high without such an operation.
- R5: With `in_first`=1 the accumulator takes the operation's product. With `in_first`=0 it takes the previous accumulator value plus the product, sign-extended to 32 bits.
- R6: The mode may change on every operation, with no idle cycle between operations. Each result uses the mode given with its own operands, and the running sum is unaffected by the switch.
- R7: In cycles with no result, `out_acc` holds its last value whatever the operand inputs carry. A later operation with `in_first`=0 continues from that held value.
- R8: After reset `out_valid` is 0 and `out_acc` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present on the operand inputs |
| in_mode | input | 1 | 0 = signed integer × integer, 1 = ternary weight × integer |
| in_first | input | 1 | 1 = load product into accumulator, 0 = add to it |
| in_act | input | 8 | Signed multiplicand (activation) |
| in_wgt | input | 8 | Signed multiplier (integer mode) or ternary code in bits [1:0] |
| out_valid | output | 1 | Accumulator updated by an operation this cycle |
| out_acc | output | 32 | Signed accumulated result |

## Verification
In integer mode every one of the 65536 operand pairs is tried with a load. This covers each Booth digit pattern, including the all-negative digit and the -128 × -128 corner. Any wrong digit weight, shift or missing carry therefore appears as a wrong product. The ternary sweep runs all activations against all four weight codes. Each is repeated with two different upper-bit fillers, which tells a correct weight mapping apart from leakage of the upper operand bits. Mixed-mode accumulation chains issued back to back, followed by idle cycles with garbage on the operands and a resumed chain, separate per-operation mode handling, load-versus-add and accumulator hold from one another.

// File: rtl/booth_mac_pkg.sv
package booth_mac_pkg;

  typedef enum logic {
    MODE_INT8 = 1'b0,
    MODE_TERN = 1'b1
  } mac_mode_e;

  // One Booth digit: value = (neg ? -1 : 1) * (one ? 1 : two ? 2 : 0)
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } booth_dig_t;

  // Radix-4 recoding of a bit triple {y[2i+1], y[2i], y[2i-1]}
  function automatic booth_dig_t booth_encode(input logic [2:0] trip);
    booth_dig_t d;
    d.one = trip[1] ^ trip[0];
    d.two = (trip == 3'b100) || (trip == 3'b011);
    d.neg = trip[2] & ~(trip[1] & trip[0]);
    return d;
  endfunction

  // Ternary weight code to a single Booth digit
  function automatic booth_dig_t tern_encode(input logic [1:0] code);
    booth_dig_t d;
    d.two = 1'b0;
    d.one = code[0];
    d.neg = code[0] & code[1];
    return d;
  endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_mac_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int NDIG  = DATA_W / 2
) (
  input  logic                   tern_mode,
  input  logic [DATA_W-1:0]      wgt,
  output booth_dig_t [NDIG-1:0]  digs
);

  logic [DATA_W:0] padded;
  assign padded = {wgt, 1'b0};

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    if (i == 0) begin : g_low
      assign digs[i] = tern_mode ? tern_encode(wgt[1:0])
                                 : booth_encode(padded[2*i+2 -: 3]);
    end else begin : g_high
      assign digs[i] = tern_mode ? booth_dig_t'('0)
                                 : booth_encode(padded[2*i+2 -: 3]);
    end
  end

endmodule

// File: rtl/booth_pp_gen.sv
module booth_pp_gen
  import booth_mac_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SHIFT  = 0,
  localparam int PROD_W = 2 * DATA_W
) (
  input  logic [DATA_W-1:0] act,
  input  booth_dig_t        dig,
  output logic [PROD_W-1:0] pp_word,
  output logic              pp_carry
);

  logic [PROD_W-1:0] ext, mag, shifted;

  assign ext     = {{(PROD_W-DATA_W){act[DATA_W-1]}}, act};
  assign mag     = dig.one ? ext : (dig.two ? (ext << 1) : '0);
  assign shifted = mag << SHIFT;
  assign pp_word = dig.neg ? ~shifted : shifted;
  assign pp_carry = dig.neg;

endmodule

// File: rtl/booth_reduce_acc.sv
module booth_reduce_acc #(
  parameter int NDIG   = 4,
  parameter int PROD_W = 16,
  parameter int ACC_W  = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_v,
  input  logic                         in_first,
  input  logic [NDIG-1:0][PROD_W-1:0]  pp,
  input  logic [NDIG-1:0]              carries,
  output logic                         out_valid,
  output logic [ACC_W-1:0]             out_acc,
  output logic [PROD_W-1:0]            product
);

  localparam int PMAX = 2 ** (PROD_W - 2);
  localparam int PMIN = -(2 ** (PROD_W - 2) - 2 ** (PROD_W / 2 - 1));

  logic [ACC_W-1:0] prod_ext;

  always_comb begin
    product = '0;
    for (int i = 0; i < NDIG; i++) begin
      product = product + pp[i] + PROD_W'(carries[i]);
    end
  end

  assign prod_ext = {{(ACC_W-PROD_W){product[PROD_W-1]}}, product};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_acc   <= '0;
    end else begin
      out_valid <= in_v;
      if (in_v) out_acc <= in_first ? prod_ext : out_acc + prod_ext;
    end
  end

  // R7: accumulator untouched when no operation reaches this stage
  assert_acc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_v |=> $stable(out_acc));

  // R1: a reduced product stays inside the signed product range
  assert_prod_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_v |-> (int'($signed(product)) <= PMAX && int'($signed(product)) >= PMIN));

endmodule

// File: rtl/booth_mac_lane.sv
module booth_mac_lane
  import booth_mac_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 32,
  localparam int NDIG   = DATA_W / 2,
  localparam int PROD_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_mode,
  input  logic              in_first,
  input  logic [DATA_W-1:0] in_act,
  input  logic [DATA_W-1:0] in_wgt,
  output logic              out_valid,
  output logic [ACC_W-1:0]  out_acc
);

  booth_dig_t [NDIG-1:0]             digs;
  logic [NDIG-1:0][PROD_W-1:0]       pp_comb;
  logic [NDIG-1:0]                   cy_comb;
  logic [NDIG-1:0][PROD_W-1:0]       s1_pp;
  logic [NDIG-1:0]                   s1_cy;
  logic                              s1_valid, s1_first;
  mac_mode_e                         s1_mode;
  logic [PROD_W-1:0]                 product;

  booth_recoder #(.DATA_W(DATA_W)) recoder_i (
    .tern_mode (in_mode),
    .wgt       (in_wgt),
    .digs      (digs)
  );

  for (genvar i = 0; i < NDIG; i++) begin : g_pp
    booth_pp_gen #(.DATA_W(DATA_W), .SHIFT(2*i)) pp_gen_i (
      .act      (in_act),
      .dig      (digs[i]),
      .pp_word  (pp_comb[i]),
      .pp_carry (cy_comb[i])
    );
  end

  // Stage 1 registers: recoded partial products
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_first <= 1'b0;
      s1_mode  <= MODE_INT8;
      s1_pp    <= '0;
      s1_cy    <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_first <= in_first;
        s1_mode  <= mac_mode_e'(in_mode);
        s1_pp    <= pp_comb;
        s1_cy    <= cy_comb;
      end
    end
  end

  // Stage 2: reduction and accumulation
  booth_reduce_acc #(.NDIG(NDIG), .PROD_W(PROD_W), .ACC_W(ACC_W)) reduce_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_v      (s1_valid),
    .in_first  (s1_first),
    .pp        (s1_pp),
    .carries   (s1_cy),
    .out_valid (out_valid),
    .out_acc   (out_acc),
    .product   (product)
  );

  // R3: in ternary mode the upper digits contribute nothing
  for (genvar i = 1; i < NDIG; i++) begin : g_chk
    assert_tern_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && s1_mode == MODE_TERN) |-> ((s1_pp[i] + PROD_W'(s1_cy[i])) == '0));
  end

  // R2: a ternary product never exceeds one multiplicand in magnitude
  assert_tern_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_mode == MODE_TERN) |->
      (int'($signed(product)) <= 2 ** (DATA_W-1) && int'($signed(product)) >= -(2 ** (DATA_W-1))));

  // R4: result exactly two edges after an accepted operation
  assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);

  assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);

endmodule

// File: tb/booth_mac_lane_tb_top.sv
module booth_mac_lane_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_mode = 1'b0, in_first = 1'b0;
  logic [7:0]  in_act = '0, in_wgt = '0;
  logic        out_valid;
  logic [31:0] out_acc;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit run_done = 1'b0;
  int model_acc = 0;

  int    exp_q[$];
  int    cyc_q[$];
  string tag_q[$];

  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  booth_mac_lane dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_first(in_first), .in_act(in_act), .in_wgt(in_wgt),
    .out_valid(out_valid), .out_acc(out_acc)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int tern_w(input logic [7:0] w);
    case (w[1:0])
      2'b01:   return 1;
      2'b11:   return -1;
      default: return 0;
    endcase
  endfunction

  // Driver: applies one operation and pushes the expected accumulator
  task automatic send(input bit mode, input logic [7:0] a, input logic [7:0] w,
                      input bit first, input string tag);
    int prod;
    @(negedge clk);
    in_valid = 1'b1; in_mode = mode; in_first = first; in_act = a; in_wgt = w;
    prod = mode ? int'($signed(a)) * tern_w(w) : int'($signed(a)) * int'($signed(w));
    model_acc = first ? prod : model_acc + prod;
    exp_q.push_back(model_acc);
    cyc_q.push_back(cyc);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n, input bit garbage);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      if (garbage) begin
        in_act = 8'(k * 37 + 5); in_wgt = 8'(k * 91 + 3);
        in_mode = k[0]; in_first = k[1];
      end
    end
  endtask

  // Monitor: pops and compares results away from the active edge
  always @(negedge clk) begin
    if (rst_n && !run_done) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 spurious out_valid", 1, 0);
        end else begin
          int e, c;
          string t;
          e = exp_q.pop_front(); c = cyc_q.pop_front(); t = tag_q.pop_front();
          check($signed(out_acc) == e, t, $signed(out_acc), e);
          check(cyc == c + 2, "R4 latency", cyc - c, 2);
        end
      end else if (cyc_q.size() != 0 && cyc > cyc_q[0] + 2) begin
        check(1'b0, "R4 missing result", cyc - cyc_q[0], 2);
        void'(exp_q.pop_front()); void'(cyc_q.pop_front()); void'(tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 reset valid", out_valid, 0);
    check(out_acc == 32'd0, "R8 reset acc", $signed(out_acc), 0);

    // R1: exhaustive signed integer products, each loaded
    for (int a = 0; a < 256; a++)
      for (int w = 0; w < 256; w++)
        send(1'b0, 8'(a), 8'(w), 1'b1, "R1 int8 product");
    send(1'b0, 8'h80, 8'h80, 1'b1, "R1 -128x-128");

    // R2 / R3: all activations, all codes, two upper-bit fillers
    for (int a = 0; a < 256; a++)
      for (int c = 0; c < 4; c++) begin
        send(1'b1, 8'(a), {6'b000000, 2'(c)}, 1'b1, "R2 ternary product");
        send(1'b1, 8'(a), {6'(a ^ 8'h2D), 2'(c)}, 1'b1, "R3 upper bits ignored");
      end

    // R5 / R6: mixed-mode back-to-back accumulation
    send(1'b0, 8'd100, 8'd90, 1'b1, "R5 load");
    for (int k = 0; k < 24; k++)
      send(k[0], 8'(k * 29 - 60), 8'(k * 53 + 7), 1'b0, "R6 mixed accumulate");
    send(1'b1, 8'h80, 8'hFF, 1'b0, "R6 tern -1 x -128 accumulate");
    send(1'b0, 8'h80, 8'h80, 1'b0, "R5 accumulate corner");

    // R7: idle with garbage, then explicit hold check and resume
    idle(6, 1'b1);
    check($signed(out_acc) == model_acc, "R7 hold while idle", $signed(out_acc), model_acc);
    check(out_valid == 1'b0, "R7 no result while idle", out_valid, 0);
    send(1'b1, 8'd77, 8'hFD, 1'b0, "R7 resume after hold");
    send(1'b0, 8'hF3, 8'd11, 1'b0, "R7 resume after hold");
    idle(4, 1'b0);

    check(exp_q.size() == 0, "R4 results outstanding", exp_q.size(), 0);
    run_done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!run_done) begin
      run_done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule